// File: doc/BRIEF.md
# Completion Space Read-Request Throttle

This block sits in the application layer of a PCI Express endpoint, on the path from a read-request source to the transaction layer's transmit side. The endpoint advertises unlimited completion credits, so link flow control cannot stop completions from overrunning the local receive buffer. The block therefore budgets each upstream memory read against a fixed local completion capacity. It forwards a request only when the worst-case completions for that request still fit in what is left of the buffer.

Two running counts are kept: completion header slots and 16-byte data segments reserved by reads still in flight. When a request is forwarded, its cost is added to both counts. When the receive side consumes completions, it reports how many slots and segments it has freed, and these are subtracted. The free amounts are the capacity minus the reserved counts and are visible on output ports.

Top module: `cpl_throttle`

## Requirements
- R1: After reset nothing is reserved: `free_hdr` equals `cap_word[7:0]` (header slots) and `free_seg` equals `cap_word[19:8]` (16-byte data segments). The capacity word is held constant while the block runs.
- R2: A forwarded request reserves ceil((req_addr[3:0] + req_len) / 16) data segments. `req_len` is in bytes, from 1 up.
- R3: A forwarded request reserves ceil((req_addr[5:0] + req_len) / 64) header slots, one for each 64-byte completion-boundary chunk it touches.
- R4: `req_ready` is high only if `tx_ready` is high and both costs are no larger than the matching free counts. A single-segment read is refused when the header slots run out, even if plenty of data segments are free.
- R5: `tx_valid` equals `req_valid` gated by the same fit test. `tx_len` and `tx_addr` carry the request's length and address unchanged.
- R6: A pulse on `rel_valid` returns `rel_hdr` header slots and `rel_seg` data segments to the free counts on the next clock edge.
- R7: A reservation and a release in the same cycle are both applied, as one net change, in that cycle.
- R8: If a release is larger than what is reserved (counting a reservation made in the same cycle), `err` is high for the following cycle and the count that would underflow is set to zero reserved.
- R9: While `tx_ready` is low, no request is taken and nothing is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_word | input | 20 | Static capacity: [7:0] header slots, [19:8] 16-byte data segments |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request taken this cycle |
| req_len | input | LEN_W | Request length in bytes |
| req_addr | input | ADDR_W | Request start address |
| tx_valid | output | 1 | Request forwarded to transmit path |
| tx_ready | input | 1 | Transmit path accepts |
| tx_len | output | LEN_W | Forwarded length |
| tx_addr | output | ADDR_W | Forwarded address |
| rel_valid | input | 1 | Completion space released this cycle |
| rel_hdr | input | 8 | Header slots released |
| rel_seg | input | 12 | Data segments released |
| free_hdr | output | 8 | Header slots not reserved |
| free_seg | output | 12 | Data segments not reserved |
| err | output | 1 | Over-release detected in the previous cycle |

## Verification
The bench uses the default LEN_W of 13 and ADDR_W of 32, but applies a small capacity of 10 header slots and 64 data segments. With a budget that small, random reads of up to 512 bytes fill either pool within a few requests. That brings refusal on headers alone, refusal on data alone, and back-to-back same-cycle reserve and release all within reach. Unaligned start offsets drive the extra segment and extra header chunk, and deliberate over-releases drive the error and clamp path.

// File: rtl/cpl_thr_pkg.sv
package cpl_thr_pkg;
  localparam int CAP_W     = 20;
  localparam int HDR_W     = 8;
  localparam int SEG_W     = 12;
  localparam int HDR_LSB   = 0;
  localparam int SEG_LSB   = 8;
  localparam int SEG_LG    = 4;   // 16-byte data segment
  localparam int RCB_LG    = 6;   // 64-byte completion boundary
endpackage

// File: rtl/cpl_thr_cost.sv
module cpl_thr_cost
  import cpl_thr_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [RCB_LG-1:0] addr_lo,
  output logic [HDR_W-1:0]  cost_hdr,
  output logic [SEG_W-1:0]  cost_seg
);
  localparam int SUM_W = LEN_W + 2;

  logic [SUM_W-1:0] span_seg;
  logic [SUM_W-1:0] span_rcb;
  logic [SUM_W-1:0] seg_full;
  logic [SUM_W-1:0] rcb_full;

  always_comb begin
    span_seg = SUM_W'(len) + SUM_W'(addr_lo[SEG_LG-1:0]);
    span_rcb = SUM_W'(len) + SUM_W'(addr_lo);
    seg_full = (span_seg + SUM_W'((1 << SEG_LG) - 1)) >> SEG_LG;
    rcb_full = (span_rcb + SUM_W'((1 << RCB_LG) - 1)) >> RCB_LG;
    cost_seg = seg_full[SEG_W-1:0];
    cost_hdr = rcb_full[HDR_W-1:0];
  end
endmodule

// File: rtl/cpl_thr_pool.sv
module cpl_thr_pool #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cap,
  input  logic         take_en,
  input  logic [W-1:0] take,
  input  logic         give_en,
  input  logic [W-1:0] give,
  output logic [W-1:0] free,
  output logic         fits,
  output logic         ovf
);
  logic [W-1:0] used_q;
  logic [W-1:0] used_d;
  logic         used_en;
  logic [W:0]   after_take;

  always_comb begin
    free       = cap - used_q;
    fits       = (take <= free);
    after_take = {1'b0, used_q} + (take_en ? {1'b0, take} : '0);
    ovf        = give_en && ({1'b0, give} > after_take);
    used_en    = take_en || give_en;
    if (ovf)
      used_d = '0;
    else if (give_en)
      used_d = W'(after_take - {1'b0, give});
    else
      used_d = after_take[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      used_q <= '0;
    else if (used_en)
      used_q <= used_d;
  end
endmodule

// File: rtl/cpl_throttle.sv
module cpl_throttle
  import cpl_thr_pkg::*;
#(
  parameter int LEN_W  = 13,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAP_W-1:0]  cap_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [LEN_W-1:0]  tx_len,
  output logic [ADDR_W-1:0] tx_addr,
  input  logic              rel_valid,
  input  logic [HDR_W-1:0]  rel_hdr,
  input  logic [SEG_W-1:0]  rel_seg,
  output logic [HDR_W-1:0]  free_hdr,
  output logic [SEG_W-1:0]  free_seg,
  output logic              err
);
  logic [HDR_W-1:0] cap_hdr;
  logic [SEG_W-1:0] cap_seg;
  logic [HDR_W-1:0] cost_hdr;
  logic [SEG_W-1:0] cost_seg;
  logic             fit_hdr;
  logic             fit_seg;
  logic             ovf_hdr;
  logic             ovf_seg;
  logic             fit;
  logic             take;
  logic             err_d;
  logic             err_q;

  assign cap_hdr = cap_word[HDR_LSB +: HDR_W];
  assign cap_seg = cap_word[SEG_LSB +: SEG_W];

  cpl_thr_cost #(.LEN_W(LEN_W)) u_cost (
    .len      (req_len),
    .addr_lo  (req_addr[RCB_LG-1:0]),
    .cost_hdr (cost_hdr),
    .cost_seg (cost_seg)
  );

  cpl_thr_pool #(.W(HDR_W)) u_hdr_pool (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap_hdr),
    .take_en (take),
    .take    (cost_hdr),
    .give_en (rel_valid),
    .give    (rel_hdr),
    .free    (free_hdr),
    .fits    (fit_hdr),
    .ovf     (ovf_hdr)
  );

  cpl_thr_pool #(.W(SEG_W)) u_seg_pool (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap_seg),
    .take_en (take),
    .take    (cost_seg),
    .give_en (rel_valid),
    .give    (rel_seg),
    .free    (free_seg),
    .fits    (fit_seg),
    .ovf     (ovf_seg)
  );

  always_comb begin
    fit       = fit_hdr && fit_seg;
    req_ready = tx_ready && fit;
    tx_valid  = req_valid && fit;
    tx_len    = req_len;
    tx_addr   = req_addr;
    take      = req_valid && req_ready;
    err_d     = ovf_hdr || ovf_seg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else
      err_q <= err_d;
  end

  assign err = err_q;
endmodule

// File: rtl/cpl_throttle_chk.sv
module cpl_throttle_chk
  import cpl_thr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rel_valid,
  input logic             err,
  input logic [HDR_W-1:0] cost_hdr,
  input logic [SEG_W-1:0] cost_seg,
  input logic [HDR_W-1:0] free_hdr,
  input logic [SEG_W-1:0] free_seg,
  input logic [HDR_W-1:0] cap_hdr,
  input logic [SEG_W-1:0] cap_seg
);
  // R4
  ready_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cost_hdr <= free_hdr) && (cost_seg <= free_seg));

  // R1
  free_in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_hdr <= cap_hdr) && (free_seg <= cap_seg));

  // R5
  fwd_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> req_valid);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !rel_valid) |=> ($stable(free_hdr) && $stable(free_seg)));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(rel_valid));
endmodule

bind cpl_throttle cpl_throttle_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rel_valid (rel_valid),
  .err       (err),
  .cost_hdr  (cost_hdr),
  .cost_seg  (cost_seg),
  .free_hdr  (free_hdr),
  .free_seg  (free_seg),
  .cap_hdr   (cap_hdr),
  .cap_seg   (cap_seg)
);

// File: tb/sim_cpl_throttle.sv
module sim_cpl_throttle;
  localparam int LEN_W  = 13;
  localparam int ADDR_W = 32;
  localparam int CAP_H  = 10;
  localparam int CAP_S  = 64;

  logic              clk;
  logic              rst_n;
  logic [19:0]       cap_word;
  logic              req_valid;
  logic              req_ready;
  logic [LEN_W-1:0]  req_len;
  logic [ADDR_W-1:0] req_addr;
  logic              tx_valid;
  logic              tx_ready;
  logic [LEN_W-1:0]  tx_len;
  logic [ADDR_W-1:0] tx_addr;
  logic              rel_valid;
  logic [7:0]        rel_hdr;
  logic [11:0]       rel_seg;
  logic [7:0]        free_hdr;
  logic [11:0]       free_seg;
  logic              err;

  int n_chk;
  int n_bad;
  int used_h;
  int used_s;
  int cycles;
  bit done;

  cpl_throttle #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int segs_of(int addr, int len);
    return ((addr % 16) + len + 15) / 16;
  endfunction

  function automatic int hdrs_of(int addr, int len);
    return ((addr % 64) + len + 63) / 64;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus with model update and checks
  task automatic step(bit rv, int len, int addr, bit txr,
                      bit relv, int rh, int rs, string tag);
    int ch, cs, nh, ns;
    bit fit, acc, e;
    @(negedge clk);
    req_valid = rv; req_len = LEN_W'(len); req_addr = ADDR_W'(addr);
    tx_ready = txr; rel_valid = relv; rel_hdr = 8'(rh); rel_seg = 12'(rs);
    #1;
    ch  = hdrs_of(addr, len);
    cs  = segs_of(addr, len);
    fit = (ch <= CAP_H - used_h) && (cs <= CAP_S - used_s);
    acc = rv && txr && fit;
    check({tag, " R4 ready"}, int'(req_ready), int'(txr && fit));
    check({tag, " R5 tx_valid"}, int'(tx_valid), int'(rv && fit));
    if (rv) begin
      check({tag, " R5 tx_len"}, int'(tx_len), len);
      check({tag, " R5 tx_addr"}, int'(tx_addr), addr);
    end
    nh = used_h + (acc ? ch : 0);
    ns = used_s + (acc ? cs : 0);
    e = 1'b0;
    if (relv) begin
      if (rh > nh) begin e = 1'b1; nh = 0; end else nh -= rh;
      if (rs > ns) begin e = 1'b1; ns = 0; end else ns -= rs;
    end
    @(posedge clk);
    #1;
    used_h = nh; used_s = ns;
    check({tag, " R2/R3/R6/R7 free_hdr"}, int'(free_hdr), CAP_H - used_h);
    check({tag, " R2/R3/R6/R7 free_seg"}, int'(free_seg), CAP_S - used_s);
    check({tag, " R8 err"}, int'(err), int'(e));
  endtask

  initial begin
    cycles = 0;
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; used_h = 0; used_s = 0; done = 1'b0;
    cap_word = 20'((CAP_S << 8) | CAP_H);
    rst_n = 1'b0; req_valid = 0; req_len = '0; req_addr = '0;
    tx_ready = 0; rel_valid = 0; rel_hdr = '0; rel_seg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 free_hdr after reset", int'(free_hdr), CAP_H);
    check("R1 free_seg after reset", int'(free_seg), CAP_S);
    check("R1 err after reset", int'(err), 0);

    // R9 stall: request offered, tx not ready
    step(1, 100, 0, 0, 0, 0, 0, "R9 stall");
    check("R9 no reservation", int'(free_seg), CAP_S);
    // R2/R3 aligned 64 bytes: 4 segs, 1 hdr
    step(1, 64, 32'h1000, 1, 0, 0, 0, "R2 aligned");
    check("R3 aligned hdr", int'(free_hdr), CAP_H - 1);
    // R2/R3 unaligned: offset 60 len 8 -> 2 segs, 2 hdrs
    step(1, 8, 32'h203c, 1, 0, 0, 0, "R3 unaligned");
    check("R2 unaligned seg", int'(free_seg), CAP_S - 6);
    // R6 release everything
    step(0, 1, 0, 1, 1, 3, 6, "R6 release");
    check("R6 all free", int'(free_hdr), CAP_H);
    // R4 header exhaustion with 4-byte reads
    for (int i = 0; i < CAP_H; i++)
      step(1, 4, 32'h3000 + i * 64, 1, 0, 0, 0, "R4 fill hdr");
    step(1, 4, 32'h4000, 1, 0, 0, 0, "R4 hdr full");
    check("R4 hdr empty, seg left", int'(free_seg), CAP_S - CAP_H);
    // R7 reserve and release together
    step(1, 4, 32'h4000, 1, 1, 1, 1, "R7 net");
    step(1, 4, 32'h4000, 1, 1, 2, 2, "R7 net2");
    // R8 over-release
    step(0, 1, 0, 1, 1, 200, 0, "R8 over");
    step(0, 1, 0, 1, 0, 0, 0, "R8 clear");
    used_h = 0; used_s = 0;
    step(0, 1, 0, 1, 1, 0, 100, "R8 over seg");
    step(0, 1, 0, 1, 1, 0, 0, "R8 clear2");

    // random phase, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      int ln, ad, rh, rs;
      bit rv, txr, relv;
      ln   = $urandom_range(1, 512);
      ad   = $urandom;
      ad   = ad & 32'h7fff_ffff;
      rv   = ($urandom_range(0, 3) != 0);
      txr  = ($urandom_range(0, 4) != 0);
      relv = ($urandom_range(0, 2) == 0);
      rh   = $urandom_range(0, used_h);
      rs   = $urandom_range(0, used_s);
      if ($urandom_range(0, 40) == 0) rs = used_s + 5;
      step(rv, ln, ad, txr, relv, rh, rs, "rand");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule